// File: doc/BRIEF.md
# Page Access Permission Checker

This block rules on a single memory access. It takes a two-bit permission code from a page or section entry, the two-bit access value of the entry's domain, the kind of access (read or write), the privilege of the requester, and two protection-control bits from the system control register. From these it works out which operations the page allows, as a read-grant flag and a write-grant flag. It also raises a fault flag when the operation asked for is not among those granted.

The result is registered. A request presented with `req_valid_i` high produces its result with `rsp_valid_o` high on the next clock edge. While no request is presented, the outputs keep the last result. A translation unit places the checker after its descriptor fetch and uses the fault flag to abort the access.

Top module: `page_perm_checker`

## Requirements
- R1: While `rst_ni` is low and after its release, until the first request, `rsp_valid_o`, `rd_ok_o`, `wr_ok_o` and `fault_o` are all 0.
- R2: A request sampled with `req_valid_i` high at a rising edge has its result on the outputs after that edge, with `rsp_valid_o` high. `rsp_valid_o` is low after an edge where `req_valid_i` was low.
- R3: Domain value 3 (manager) grants both read and write, whatever the permission code, privilege and protection bits are.
- R4: With domain value 0, 1 or 2 and permission code 0, write is never granted. If `sys_prot_i`=1 and `rom_prot_i`=0, a privileged access (`user_i`=0) is granted read and a user access (`user_i`=1) is granted nothing.
- R5: With domain value 0, 1 or 2, permission code 0, `rom_prot_i`=1 and `sys_prot_i`=0, read is granted to both privileged and user accesses, and write is not.
- R6: With domain value 0, 1 or 2, permission code 0, and both protection bits equal (both 0 or both 1), nothing is granted.
- R7: With domain value 0, 1 or 2 and permission code 1, a privileged access is granted read and write, and a user access is granted nothing.
- R8: With domain value 0, 1 or 2 and permission code 2, a privileged access is granted read and write, and a user access is granted read only.
- R9: With domain value 0, 1 or 2 and permission code 3, every access is granted read and write.
- R10: `fault_o` is 1 exactly when the requested operation (`write_i`=1 means write, 0 means read) is not granted in the same result.
- R11: After an edge where `req_valid_i` was low, `rd_ok_o`, `wr_ok_o` and `fault_o` keep their previous values, whatever the other inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| ap_i | input | 2 | Permission code of the page or section |
| dom_i | input | 2 | Access value of the domain; 3 means manager |
| write_i | input | 1 | 1 for a write, 0 for a read |
| user_i | input | 1 | 1 for an unprivileged requester |
| sys_prot_i | input | 1 | System protection control bit |
| rom_prot_i | input | 1 | ROM protection control bit |
| rsp_valid_o | output | 1 | The result of the previous request is on the outputs |
| rd_ok_o | output | 1 | Read is granted |
| wr_ok_o | output | 1 | Write is granted |
| fault_o | output | 1 | The requested operation is not granted |

## Verification
The properties assume that every request input is at a known value whenever `req_valid_i` is high. Their `$past` terms look back only at edges after reset, where a request was sampled. The stimulus changes inputs only on falling edges, so every field is stable around the rising edge. Random requests cover all four domain values, all four permission codes and every combination of the protection bits, with idle cycles mixed in. Those idle cycles drive the request fields with random values, so the hold behaviour is tested against inputs that would change the result if they were used.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int unsigned CODE_W = 2;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t DOM_MANAGER = code_t'(3);

  typedef enum logic [CODE_W-1:0] {
    AP_CTRL   = 2'd0,
    AP_PRIV   = 2'd1,
    AP_USR_RO = 2'd2,
    AP_FULL   = 2'd3
  } ap_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } grant_t;
endpackage

// File: rtl/apc_grant.sv
module apc_grant
  import apc_pkg::*;
(
  input  code_t  ap_i,
  input  code_t  dom_i,
  input  logic   user_i,
  input  logic   sys_prot_i,
  input  logic   rom_prot_i,
  output grant_t grant_o
);
  always_comb begin
    grant_o = '0;
    if (dom_i == DOM_MANAGER) begin
      grant_o = '{rd: 1'b1, wr: 1'b1};
    end else begin
      unique case (ap_e'(ap_i))
        AP_CTRL: begin
          // exactly one protection bit set selects a read-only view
          if (sys_prot_i ^ rom_prot_i) grant_o.rd = rom_prot_i | ~user_i;
        end
        AP_PRIV:   grant_o = '{rd: ~user_i, wr: ~user_i};
        AP_USR_RO: grant_o = '{rd: 1'b1,    wr: ~user_i};
        AP_FULL:   grant_o = '{rd: 1'b1,    wr: 1'b1};
        default:   grant_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/apc_fault.sv
module apc_fault
  import apc_pkg::*;
(
  input  grant_t grant_i,
  input  logic   write_i,
  output logic   fault_o
);
  always_comb fault_o = write_i ? ~grant_i.wr : ~grant_i.rd;
endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker
  import apc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] ap_i,
  input  logic [CODE_W-1:0] dom_i,
  input  logic              write_i,
  input  logic              user_i,
  input  logic              sys_prot_i,
  input  logic              rom_prot_i,
  output logic              rsp_valid_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              fault_o
);
  grant_t grant_d;
  logic   fault_d;

  apc_grant u_grant (
    .ap_i       (ap_i),
    .dom_i      (dom_i),
    .user_i     (user_i),
    .sys_prot_i (sys_prot_i),
    .rom_prot_i (rom_prot_i),
    .grant_o    (grant_d)
  );

  apc_fault u_fault (
    .grant_i (grant_d),
    .write_i (write_i),
    .fault_o (fault_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rd_ok_o     <= 1'b0;
      wr_ok_o     <= 1'b0;
      fault_o     <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rd_ok_o <= grant_d.rd;
        wr_ok_o <= grant_d.wr;
        fault_o <= fault_d;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(rd_ok_o) && $stable(wr_ok_o) && $stable(fault_o)));

  p_manager_rw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dom_i == DOM_MANAGER) |=> (rd_ok_o && wr_ok_o && !fault_o));

  p_ap0_no_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dom_i != DOM_MANAGER && ap_i == CODE_W'(0)) |=> !wr_ok_o);

  p_ap3_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ap_i == CODE_W'(3)) |=> (rd_ok_o && wr_ok_o));

  p_fault_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (fault_o == ($past(write_i) ? !wr_ok_o : !rd_ok_o)));
endmodule

// File: tb/tb_page_perm_checker.sv
module tb_page_perm_checker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] ap_i = '0;
  logic [1:0] dom_i = '0;
  logic       write_i = 1'b0;
  logic       user_i = 1'b0;
  logic       sys_prot_i = 1'b0;
  logic       rom_prot_i = 1'b0;
  logic       rsp_valid_o, rd_ok_o, wr_ok_o, fault_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit e_rd = 1'b0, e_wr = 1'b0, e_fl = 1'b0;

  always #5 clk_i = ~clk_i;

  page_perm_checker dut (.*);

  function automatic logic [1:0] model(input logic [1:0] ap, input logic [1:0] dom,
                                       input logic usr, input logic sp, input logic rp);
    if (dom == 2'd3) return 2'b11;
    case (ap)
      2'd0: begin
        if (sp && !rp) return usr ? 2'b00 : 2'b10;
        if (rp && !sp) return 2'b10;
        return 2'b00;
      end
      2'd1: return usr ? 2'b00 : 2'b11;
      2'd2: return usr ? 2'b10 : 2'b11;
      default: return 2'b11;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] ap, input logic [1:0] dom,
                                   input logic sp, input logic rp);
    if (dom == 2'd3) return "R3";
    case (ap)
      2'd0: return (sp && !rp) ? "R4" : (rp && !sp) ? "R5" : "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] ap, input logic [1:0] dom,
                      input logic wr, input logic usr, input logic sp, input logic rp);
    logic [1:0] g;
    string t;
    req_valid_i = v; ap_i = ap; dom_i = dom; write_i = wr;
    user_i = usr; sys_prot_i = sp; rom_prot_i = rp;
    if (v) begin
      g = model(ap, dom, usr, sp, rp);
      e_rd = g[1]; e_wr = g[0];
      e_fl = wr ? !g[0] : !g[1];
      t = tag_of(ap, dom, sp, rp);
    end else begin
      t = "R11";
    end
    @(negedge clk_i);
    check("R2", "rsp_valid", int'(rsp_valid_o), int'(v));
    check(t, "rd_ok", int'(rd_ok_o), int'(e_rd));
    check(t, "wr_ok", int'(wr_ok_o), int'(e_wr));
    check(v ? "R10" : "R11", "fault", int'(fault_o), int'(e_fl));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk_i);
    // R1: outputs low during reset
    check("R1", "rsp_valid", int'(rsp_valid_o), 0);
    check("R1", "rd_ok", int'(rd_ok_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "wr_ok", int'(wr_ok_o), 0);
    check("R1", "fault", int'(fault_o), 0);

    // directed corners
    for (int u = 0; u < 2; u++) begin
      for (int w = 0; w < 2; w++) begin
        step(1, 2'd0, 2'd3, w[0], u[0], 1, 1);  // R3 manager over AP0
        step(1, 2'd0, 2'd1, w[0], u[0], 1, 0);  // R4
        step(1, 2'd0, 2'd1, w[0], u[0], 0, 1);  // R5
        step(1, 2'd0, 2'd0, w[0], u[0], 0, 0);  // R6
        step(1, 2'd0, 2'd2, w[0], u[0], 1, 1);  // R6
        step(1, 2'd1, 2'd1, w[0], u[0], 0, 0);  // R7
        step(1, 2'd2, 2'd1, w[0], u[0], 1, 0);  // R8
        step(1, 2'd3, 2'd0, w[0], u[0], 0, 1);  // R9
      end
    end
    // R11: idle after a granted write, inputs set to deny everything
    step(1, 2'd3, 2'd1, 1, 1, 0, 0);
    step(0, 2'd0, 2'd0, 1, 1, 0, 0);
    step(0, 2'd1, 2'd2, 0, 1, 1, 1);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[9:8] != 2'd0, r[1:0], r[3:2], r[4], r[5], r[6], r[7]);
    end
    finish_run();
  end
endmodule